// File: doc/BRIEF.md
# PCIe Root Port Interrupt Aggregator

This block collects every interrupt cause of a PCIe root port into one host interrupt line. Four legacy INTx wires from the link side are level-sensitive. Message-signalled interrupts reach the block as vector numbers from an inbound-write decoder; each one is an edge event. Software sees four 32-bit registers behind a simple single-cycle register port:

- a cause-enable register;
- a pending register that shows the four INTx causes and one MSI summary bit;
- a read-only register that returns the address devices must write to raise an MSI;
- a per-vector pending register with 32 bits.

Both pending registers are write-one-to-clear. The two kinds of cause behave differently after a clear. An INTx bit comes back while its wire stays high. An MSI vector bit is set once per event and stays set until software clears it. The summary bit in the pending register follows the vector register and also follows new events. The host line is high whenever a pending cause is also enabled.

Top module: `pcie_irq_agg`

## Requirements
- R1: After reset the enable register, both pending registers and `irq_o` are all zero, so every cause is masked.
- R2: The register map is as follows. Enable is at byte offset 0x180 and pending at 0x184; in both, bits 24..27 are INTA..INTD and bit 28 is the MSI summary. The MSI target address is at 0x190 and the vector pending register at 0x194, with bit n for vector n. Bits not listed read 0 and ignore writes, and unmapped offsets read 0. `rdata_o` follows `addr_i` in the same cycle.
- R3: An INTx pending bit sets at the first clock edge at which its input is high. It stays set while the input stays high.
- R4: Writing 1 to an INTx pending bit clears it at that write's edge. If the input is still high, the bit reads 0 for one cycle and sets again at the next edge.
- R5: A cycle with `msi_valid_i` high sets bit `msi_vec_i` of the vector pending register at that edge. The bit stays set until software writes 1 to it.
- R6: A write of ones to 0x194 clears only the written bits. An event that arrives in the same cycle as the clear of its own bit leaves that bit set.
- R7: The MSI summary bit sets at the edge of any event, and at every edge at which a vector pending bit is set. A write of 1 to bit 28 clears it only when neither of those holds.
- R8: `irq_o` is high exactly when the pending register ANDed with the enable register is nonzero.
- R9: Offset 0x190 returns the parameter `MSI_TARGET`. Writes to 0x190 change no register.
- R10: With the INTx inputs low and no events, writing all ones to 0x194 and then to 0x184 clears every pending cause.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register access strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| intx_i | input | 4 | INTA..INTD level inputs |
| msi_valid_i | input | 1 | MSI event strobe |
| msi_vec_i | input | 5 | MSI vector number |
| irq_o | output | 1 | Combined host interrupt |

## Verification
Two functions can land in the same clock: a software write-one-to-clear of a pending bit, and the hardware set of that same bit. The bench provokes this in two ways. It drives an MSI event and a clear of the vector register on one edge, once on the same bit and once on a different bit. It also clears an INTx bit while the INTx wire is held high. Each outcome is judged against the rule for its kind of cause: an MSI bit survives its clear, while an INTx bit shows 0 for one cycle and then sets again.

// File: rtl/pcie_irq_pkg.sv
package pcie_irq_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ADDR_W  = 12;
  localparam logic [ADDR_W-1:0] OFF_EN     = 12'h180;
  localparam logic [ADDR_W-1:0] OFF_PEND   = 12'h184;
  localparam logic [ADDR_W-1:0] OFF_TARGET = 12'h190;
  localparam logic [ADDR_W-1:0] OFF_VEC    = 12'h194;
  localparam int unsigned INTX_LSB = 24;
  localparam int unsigned SUM_BIT  = 28;
endpackage

// File: rtl/pcie_irq_intx.sv
module pcie_irq_intx #(
  parameter int unsigned N_INTX = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_INTX-1:0] level_i,
  input  logic [N_INTX-1:0] clr_i,
  output logic [N_INTX-1:0] pend_o
);
  for (genvar k = 0; k < N_INTX; k++) begin : g_pin
    logic pend_q;
    // clear wins for one cycle; a held level re-arms at the next edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       pend_q <= 1'b0;
      else if (clr_i[k]) pend_q <= 1'b0;
      else if (level_i[k]) pend_q <= 1'b1;
    end
    assign pend_o[k] = pend_q;

    p_intx_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      level_i[k] && !clr_i[k] |=> pend_o[k]);
    p_intx_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[k] |=> !pend_o[k]);
  end
endmodule

// File: rtl/pcie_irq_msi.sv
module pcie_irq_msi #(
  parameter int unsigned N_VEC = 32,
  localparam int unsigned VEC_W = $clog2(N_VEC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ev_valid_i,
  input  logic [VEC_W-1:0] ev_vec_i,
  input  logic [N_VEC-1:0] clr_i,
  input  logic             sum_clr_i,
  output logic [N_VEC-1:0] vec_o,
  output logic             sum_o
);
  logic [N_VEC-1:0] vec_q, set_vec;
  logic             sum_q;

  assign set_vec = ev_valid_i ? (N_VEC'(1) << ev_vec_i) : '0;

  // set wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vec_q <= '0;
    else         vec_q <= (vec_q & ~clr_i) | set_vec;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_q <= 1'b0;
    else         sum_q <= (sum_q & ~sum_clr_i) | ev_valid_i | (|vec_q);
  end

  assign vec_o = vec_q;
  assign sum_o = sum_q;

  for (genvar b = 0; b < N_VEC; b++) begin : g_chk
    p_vec_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_valid_i && ev_vec_i == VEC_W'(b) |=> vec_o[b]);
    p_vec_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[b] && !(ev_valid_i && ev_vec_i == VEC_W'(b)) |=> !vec_o[b]);
    p_vec_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vec_o[b] && !clr_i[b] |=> vec_o[b]);
  end
  p_sum_follow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|vec_o) || ev_valid_i |=> sum_o);
endmodule

// File: rtl/pcie_irq_regs.sv
module pcie_irq_regs
  import pcie_irq_pkg::*;
#(
  parameter int unsigned  N_INTX     = 4,
  parameter int unsigned  N_VEC      = 32,
  parameter logic [31:0]  MSI_TARGET = 32'h1FF0_0040,
  localparam int unsigned N_CAUSE    = N_INTX + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_INTX-1:0] intx_pend_i,
  input  logic [N_VEC-1:0]  vec_pend_i,
  input  logic              sum_pend_i,
  output logic [N_INTX-1:0] intx_clr_o,
  output logic [N_VEC-1:0]  vec_clr_o,
  output logic              sum_clr_o,
  output logic              irq_o
);
  logic [N_CAUSE-1:0] en_q, pend_w;
  logic [DATA_W-1:0]  en_word, pend_word;
  logic               wr_en, wr_pend, wr_vec;

  assign wr_en   = sel_i && wr_i && addr_i == OFF_EN;
  assign wr_pend = sel_i && wr_i && addr_i == OFF_PEND;
  assign wr_vec  = sel_i && wr_i && addr_i == OFF_VEC;

  assign pend_w = {sum_pend_i, intx_pend_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    en_q <= '0;
    else if (wr_en) en_q <= {wdata_i[SUM_BIT], wdata_i[INTX_LSB +: N_INTX]};
  end

  assign intx_clr_o = wr_pend ? wdata_i[INTX_LSB +: N_INTX] : '0;
  assign sum_clr_o  = wr_pend && wdata_i[SUM_BIT];
  assign vec_clr_o  = wr_vec ? wdata_i[N_VEC-1:0] : '0;

  always_comb begin
    en_word = '0;
    en_word[INTX_LSB +: N_INTX] = en_q[N_INTX-1:0];
    en_word[SUM_BIT] = en_q[N_INTX];
    pend_word = '0;
    pend_word[INTX_LSB +: N_INTX] = pend_w[N_INTX-1:0];
    pend_word[SUM_BIT] = pend_w[N_INTX];
  end

  always_comb begin
    unique case (addr_i)
      OFF_EN:     rdata_o = en_word;
      OFF_PEND:   rdata_o = pend_word;
      OFF_TARGET: rdata_o = MSI_TARGET;
      OFF_VEC:    rdata_o = DATA_W'(vec_pend_i);
      default:    rdata_o = '0;
    endcase
  end

  assign irq_o = |(pend_w & en_q);

  p_en_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> en_q == {$past(wdata_i[SUM_BIT]), $past(wdata_i[INTX_LSB +: N_INTX])});
  p_masked_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q == '0 |-> !irq_o);
  p_idle_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_w == '0 |-> !irq_o);
endmodule

// File: rtl/pcie_irq_agg.sv
module pcie_irq_agg
  import pcie_irq_pkg::*;
#(
  parameter int unsigned  N_INTX     = 4,
  parameter int unsigned  N_VEC      = 32,
  parameter logic [31:0]  MSI_TARGET = 32'h1FF0_0040,
  localparam int unsigned VEC_W      = $clog2(N_VEC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [11:0]       addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [N_INTX-1:0] intx_i,
  input  logic              msi_valid_i,
  input  logic [VEC_W-1:0]  msi_vec_i,
  output logic              irq_o
);
  logic [N_INTX-1:0] intx_pend, intx_clr;
  logic [N_VEC-1:0]  vec_pend, vec_clr;
  logic              sum_pend, sum_clr;

  pcie_irq_intx #(.N_INTX(N_INTX)) u_intx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (intx_i),
    .clr_i   (intx_clr),
    .pend_o  (intx_pend)
  );

  pcie_irq_msi #(.N_VEC(N_VEC)) u_msi (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ev_valid_i (msi_valid_i),
    .ev_vec_i   (msi_vec_i),
    .clr_i      (vec_clr),
    .sum_clr_i  (sum_clr),
    .vec_o      (vec_pend),
    .sum_o      (sum_pend)
  );

  pcie_irq_regs #(
    .N_INTX     (N_INTX),
    .N_VEC      (N_VEC),
    .MSI_TARGET (MSI_TARGET)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_i       (sel_i),
    .wr_i        (wr_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .rdata_o     (rdata_o),
    .intx_pend_i (intx_pend),
    .vec_pend_i  (vec_pend),
    .sum_pend_i  (sum_pend),
    .intx_clr_o  (intx_clr),
    .vec_clr_o   (vec_clr),
    .sum_clr_o   (sum_clr),
    .irq_o       (irq_o)
  );

  p_reset_quiet_r1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> !irq_o);
endmodule

// File: tb/pcie_irq_agg_test.sv
module pcie_irq_agg_test;
  localparam logic [31:0] TGT = 32'h2468_ACE0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [3:0]  intx = '0;
  logic        mv = 1'b0;
  logic [4:0]  mvec = '0;
  logic        irq;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pcie_irq_agg #(.MSI_TARGET(TGT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .intx_i(intx), .msi_valid_i(mv),
    .msi_vec_i(mvec), .irq_o(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic reg_rd(logic [11:0] a, output logic [31:0] d);
    addr = a; sel = 1; wr = 0; #1; d = rdata; sel = 0;
  endtask

  task automatic rd_chk(string req, logic [11:0] a, logic [31:0] exp);
    logic [31:0] d;
    reg_rd(a, d);
    check(req, d, exp);
  endtask

  task automatic msi(logic [4:0] v);
    @(negedge clk); mv = 1; mvec = v;
    @(negedge clk); mv = 0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd_chk("R1 enable", 12'h180, 0);
    rd_chk("R1 pending", 12'h184, 0);
    rd_chk("R1 vector", 12'h194, 0);
    check("R1 irq", 32'(irq), 0);

    // R2 map, unimplemented bits and unmapped offsets
    reg_wr(12'h180, 32'hFFFF_FFFF);
    rd_chk("R2 enable bits", 12'h180, 32'h1F00_0000);
    rd_chk("R2 unmapped", 12'h188, 0);
    reg_wr(12'h180, 0);

    // R3 latency, R4 clear with held level
    @(negedge clk); intx = 4'b0001;
    rd_chk("R3 not before edge", 12'h184, 0);
    @(negedge clk);
    rd_chk("R3 set", 12'h184, 32'h0100_0000);
    reg_wr(12'h184, 32'h0100_0000);
    rd_chk("R4 cleared one cycle", 12'h184, 0);
    @(negedge clk);
    rd_chk("R4 re-set while high", 12'h184, 32'h0100_0000);
    intx = 0;
    reg_wr(12'h184, 32'hFFFF_FFFF);
    rd_chk("R4 stays clear once low", 12'h184, 0);

    // R3 sweep of all INTx patterns
    for (int p = 0; p < 16; p++) begin
      @(negedge clk); intx = 4'(p);
      @(negedge clk);
      rd_chk("R3 sweep", 12'h184, 32'(p) << 24);
      intx = 0;
      reg_wr(12'h184, 32'hFFFF_FFFF);
      rd_chk("R10 sweep clear", 12'h184, 0);
    end

    // R5/R7 vector sweep
    for (int v = 0; v < 32; v++) begin
      msi(5'(v));
      rd_chk("R5 vector set", 12'h194, 32'h1 << v);
      rd_chk("R7 summary set", 12'h184, 32'h1000_0000);
      reg_wr(12'h194, 32'h1 << v);
      rd_chk("R5 vector clear", 12'h194, 0);
      reg_wr(12'h184, 32'h1000_0000);
      rd_chk("R7 summary clear", 12'h184, 0);
    end

    // R6 partial clear and same-cycle set/clear
    msi(5'd3); msi(5'd9);
    rd_chk("R5 sticky pair", 12'h194, 32'h0000_0208);
    reg_wr(12'h194, 32'h0000_0008);
    rd_chk("R6 partial clear", 12'h194, 32'h0000_0200);
    @(negedge clk); mv = 1; mvec = 5'd9; sel = 1; wr = 1; addr = 12'h194; wdata = 32'h200;
    @(negedge clk); mv = 0; sel = 0; wr = 0;
    rd_chk("R6 set beats clear same bit", 12'h194, 32'h0000_0200);
    @(negedge clk); mv = 1; mvec = 5'd4; sel = 1; wr = 1; addr = 12'h194; wdata = 32'h200;
    @(negedge clk); mv = 0; sel = 0; wr = 0;
    rd_chk("R6 clear other bit", 12'h194, 32'h0000_0010);

    // R7 summary cannot clear while a vector is pending
    reg_wr(12'h184, 32'h1000_0000);
    rd_chk("R7 summary held", 12'h184, 32'h1000_0000);

    // R8 enable sweep with pending = INTA, INTC, summary
    @(negedge clk); intx = 4'b0101;
    @(negedge clk);
    rd_chk("R3 pattern for R8", 12'h184, 32'h1500_0000);
    for (int m = 0; m < 32; m++) begin
      reg_wr(12'h180, 32'(m) << 24);
      rd_chk("R2 enable readback", 12'h180, 32'(m) << 24);
      check("R8 irq", 32'(irq), 32'((m & 5'b10101) != 0));
    end

    // R9 target read-only
    rd_chk("R9 target", 12'h190, TGT);
    reg_wr(12'h190, 32'h0BAD_F00D);
    rd_chk("R9 target after write", 12'h190, TGT);
    rd_chk("R9 enable untouched", 12'h180, 32'h1F00_0000);
    rd_chk("R9 vector untouched", 12'h194, 32'h0000_0010);

    // R10 clear everything
    intx = 0;
    reg_wr(12'h194, 32'hFFFF_FFFF);
    reg_wr(12'h184, 32'hFFFF_FFFF);
    rd_chk("R10 vector empty", 12'h194, 0);
    rd_chk("R10 pending empty", 12'h184, 0);
    check("R10 irq low", 32'(irq), 0);

    done = 1;
    finish_run();
  end
endmodule